// File: doc/BRIEF.md
# Literal-Prefix Data Stack Front End

This block is the top-of-stack section of a two-register stack machine. The two topmost data words sit in registers (the top word and the word beneath it), and all deeper words live in a small stack RAM. A data-stack pointer addresses that RAM and always names the topmost occupied RAM entry. An instruction decoder outside the block sends one stack command each cycle: hold, push, pop, load the top word, pop-and-load, push-and-load, or literal nibble. Any new top-word value that is not a literal arrives on an input port. The block has no ALU, no instruction decoding and no return stack.

Constants of any size are built from a run of signed 7-bit nibbles. A nibble that follows a non-literal command is sign-extended to the full data width and pushed. Each nibble after that shifts the top word left by seven bits and fills the freed low bits. A one-bit literal flag remembers whether the previous command was a nibble. This flag is the state of a two-state machine: `ST_OPC` (the previous command was not a nibble) and `ST_LIT` (the previous command was a nibble). A nibble command takes the transition `ST_OPC -> ST_LIT` (push) or `ST_LIT -> ST_LIT` (shift). Any other command returns the machine to `ST_OPC`.

Software can read the stack pointer and can overwrite it, so that it can switch between several stacks held in the same RAM. The pointer wraps around at both ends. Nothing detects overflow or underflow.

Top module: `nibble_stack_front`

## Requirements
- R1: A synchronous active-high reset sets the top word, the second word, the stack pointer and the literal flag to zero. Stack RAM contents are kept.
- R2: Command code 6 (nibble) arriving while the literal flag is 0 does the following. The 7-bit nibble, sign-extended, becomes the top word. The old top word becomes the second word. The old second word is written to RAM entry pointer+1, and the pointer increments.
- R3: Command code 6 arriving while the literal flag is 1 sets the top word to (top << 7) | nibble, truncated to the data width. The second word and the pointer do not change.
- R4: The literal flag reads 1 after a cycle whose command was code 6, and 0 after a cycle with any other command code.
- R5: Command code 1 (push) copies the top word into the second word and writes the old second word to RAM entry pointer+1. The pointer increments and the top word is unchanged.
- R6: Command code 2 (pop) moves the second word into the top word and loads the second word from RAM entry at the pointer. The pointer decrements.
- R7: Command code 3 (load) replaces the top word with the value input. The second word and the pointer do not change.
- R8: Command code 4 (pop-load) acts as a pop, except that the top word takes the value input. Command code 5 (push-load) acts as a push, except that the top word takes the value input.
- R9: Command codes 0 (hold) and 7 (reserved) leave the top word, the second word and the pointer unchanged.
- R10: When the pointer write enable is high, the pointer takes the written value instead of its push or pop step. The command still moves data, and it uses RAM addresses based on the old pointer.
- R11: The pointer wraps from DEPTH-1 to 0 on a push and from 0 to DEPTH-1 on a pop, with no other effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 3 | Stack command code |
| nib | input | 7 | Signed literal nibble, used by command 6 |
| tos_in | input | DATA_W | New top-word value for commands 3, 4 and 5 |
| sp_we | input | 1 | Stack pointer write enable |
| sp_wdata | input | PTR_W | Value written to the stack pointer |
| tos | output | DATA_W | Top word |
| nos | output | DATA_W | Second word |
| sp | output | PTR_W | Stack pointer |
| lit | output | 1 | Literal flag: the previous command was a nibble |

## Verification
The clocked properties assume that the command code and the pointer write port are driven to known values on every clock edge outside reset. They also assume that a pop reads only RAM entries that were written earlier. The stimulus fills every RAM entry with pushes before the first pop, so this second assumption holds. It drives all inputs half a cycle away from the sampling edge and never leaves a command input floating. Commands with and without a pointer write are mixed so that the override path is exercised under all three data movements.

// File: rtl/nsf_pkg.sv
package nsf_pkg;

    typedef enum logic [2:0] {
        CMD_HOLD   = 3'd0,
        CMD_PUSH   = 3'd1,
        CMD_POP    = 3'd2,
        CMD_LOAD   = 3'd3,
        CMD_POPLD  = 3'd4,
        CMD_PUSHLD = 3'd5,
        CMD_NIB    = 3'd6,
        CMD_RSVD   = 3'd7
    } cmd_e;

    typedef enum logic {
        ST_OPC = 1'b0,
        ST_LIT = 1'b1
    } lit_state_e;

    typedef enum logic [2:0] {
        TS_KEEP,
        TS_NOS,
        TS_IN,
        TS_NIB_EXT,
        TS_NIB_SHIFT
    } tos_src_e;

    typedef enum logic [1:0] {
        NS_KEEP,
        NS_TOS,
        NS_RAM
    } nos_src_e;

    localparam int NIB_W = 7;

endpackage

// File: rtl/nsf_stack_ram.sv
module nsf_stack_ram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/nsf_ptr.sv
module nsf_ptr #(
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_val,
    output logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] ptr_inc
);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_d;

    assign ptr_inc = ptr_q + PTR_W'(1);

    always_comb begin
        ptr_d = ptr_q;
        if (wr_en) begin
            ptr_d = wr_val;
        end else if (step_up) begin
            ptr_d = ptr_inc;
        end else if (step_dn) begin
            ptr_d = ptr_q - PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr = ptr_q;

    // R10
    ptr_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ptr_q == $past(wr_val));

    // R11
    ptr_up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step_up && !wr_en && ptr_q == PTR_W'(DEPTH-1)) |=> ptr_q == '0);

    // R11
    ptr_dn_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step_dn && !wr_en && ptr_q == '0) |=> ptr_q == PTR_W'(DEPTH-1));

endmodule

// File: rtl/nsf_lit_fsm.sv
module nsf_lit_fsm
    import nsf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_e cmd,
    output logic lit,
    output logic nib_push,
    output logic nib_shift
);

    lit_state_e state_q;
    lit_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_OPC:  state_d = (cmd == CMD_NIB) ? ST_LIT : ST_OPC;
            ST_LIT:  state_d = (cmd == CMD_NIB) ? ST_LIT : ST_OPC;
            default: state_d = ST_OPC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OPC;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        lit       = 1'b0;
        nib_push  = 1'b0;
        nib_shift = 1'b0;
        unique case (state_q)
            ST_OPC: begin
                nib_push = (cmd == CMD_NIB);
            end
            ST_LIT: begin
                lit       = 1'b1;
                nib_shift = (cmd == CMD_NIB);
            end
            default: ;
        endcase
    end

    // R4
    lit_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_NIB) |=> lit);

    // R4
    lit_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NIB) |=> !lit);

endmodule

// File: rtl/nibble_stack_front.sv
module nibble_stack_front
    import nsf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd,
    input  logic [6:0]        nib,
    input  logic [DATA_W-1:0] tos_in,
    input  logic              sp_we,
    input  logic [PTR_W-1:0]  sp_wdata,
    output logic [DATA_W-1:0] tos,
    output logic [DATA_W-1:0] nos,
    output logic [PTR_W-1:0]  sp,
    output logic              lit
);

    localparam int EXT_W = DATA_W - NIB_W;

    cmd_e              cmd_v;
    logic              nib_push;
    logic              nib_shift;
    logic              step_up;
    logic              step_dn;
    tos_src_e          tos_src;
    nos_src_e          nos_src;
    logic [DATA_W-1:0] tos_q;
    logic [DATA_W-1:0] nos_q;
    logic [DATA_W-1:0] tos_d;
    logic [DATA_W-1:0] nos_d;
    logic [DATA_W-1:0] ram_rd;
    logic [DATA_W-1:0] nib_ext;
    logic [DATA_W-1:0] nib_shl;
    logic [PTR_W-1:0]  ptr_inc;

    assign cmd_v = cmd_e'(cmd);

    nsf_lit_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd_v),
        .lit       (lit),
        .nib_push  (nib_push),
        .nib_shift (nib_shift)
    );

    generate
        if (EXT_W > 0) begin : g_ext
            assign nib_ext = {{EXT_W{nib[NIB_W-1]}}, nib};
            assign nib_shl = {tos_q[EXT_W-1:0], nib};
        end else begin : g_narrow
            assign nib_ext = nib[DATA_W-1:0];
            assign nib_shl = nib[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        tos_src = TS_KEEP;
        nos_src = NS_KEEP;
        step_up = 1'b0;
        step_dn = 1'b0;
        unique case (cmd_v)
            CMD_HOLD, CMD_RSVD: ;
            CMD_PUSH: begin
                nos_src = NS_TOS;
                step_up = 1'b1;
            end
            CMD_POP: begin
                tos_src = TS_NOS;
                nos_src = NS_RAM;
                step_dn = 1'b1;
            end
            CMD_LOAD: begin
                tos_src = TS_IN;
            end
            CMD_POPLD: begin
                tos_src = TS_IN;
                nos_src = NS_RAM;
                step_dn = 1'b1;
            end
            CMD_PUSHLD: begin
                tos_src = TS_IN;
                nos_src = NS_TOS;
                step_up = 1'b1;
            end
            CMD_NIB: begin
                if (nib_push) begin
                    tos_src = TS_NIB_EXT;
                    nos_src = NS_TOS;
                    step_up = 1'b1;
                end else if (nib_shift) begin
                    tos_src = TS_NIB_SHIFT;
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        unique case (tos_src)
            TS_NOS:       tos_d = nos_q;
            TS_IN:        tos_d = tos_in;
            TS_NIB_EXT:   tos_d = nib_ext;
            TS_NIB_SHIFT: tos_d = nib_shl;
            default:      tos_d = tos_q;
        endcase
        unique case (nos_src)
            NS_TOS:  nos_d = tos_q;
            NS_RAM:  nos_d = ram_rd;
            default: nos_d = nos_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tos_q <= '0;
            nos_q <= '0;
        end else begin
            tos_q <= tos_d;
            nos_q <= nos_d;
        end
    end

    nsf_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .step_up (step_up),
        .step_dn (step_dn),
        .wr_en   (sp_we),
        .wr_val  (sp_wdata),
        .ptr     (sp),
        .ptr_inc (ptr_inc)
    );

    nsf_stack_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (step_up & ~rst),
        .waddr (ptr_inc),
        .wdata (nos_q),
        .raddr (sp),
        .rdata (ram_rd)
    );

    assign tos = tos_q;
    assign nos = nos_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (tos == '0 && nos == '0 && sp == '0 && !lit));

    // R3
    shift_no_move_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd6 && lit && !sp_we) |=> ($stable(sp) && $stable(nos)));

    // R5
    push_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd1) |=> (nos == $past(tos) && tos == $past(tos)));

    // R6
    pop_move_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd2) |=> tos == $past(nos));

    // R7
    load_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd3 && !sp_we) |=> (tos == $past(tos_in) && $stable(nos) && $stable(sp)));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ((cmd == 3'd0 || cmd == 3'd7) && !sp_we) |=> ($stable(tos) && $stable(nos) && $stable(sp)));

endmodule

// File: tb/nibble_stack_front_test.sv
module nibble_stack_front_test;

    localparam int W = 16;
    localparam int D = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   cmd = 3'd0;
    logic [6:0]   nib = '0;
    logic [W-1:0] tos_in = '0;
    logic         sp_we = 1'b0;
    logic [3:0]   sp_wdata = '0;
    logic [W-1:0] tos;
    logic [W-1:0] nos;
    logic [3:0]   sp;
    logic         lit;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] m_tos = '0;
    logic [W-1:0] m_nos = '0;
    int           m_sp  = 0;
    logic         m_lit = 1'b0;
    logic [W-1:0] m_ram [D];

    always #2 clk = ~clk;

    nibble_stack_front #(.DATA_W(W), .DEPTH(D)) uut (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .nib      (nib),
        .tos_in   (tos_in),
        .sp_we    (sp_we),
        .sp_wdata (sp_wdata),
        .tos      (tos),
        .nos      (nos),
        .sp       (sp),
        .lit      (lit)
    );

    task automatic check(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "tos", tos, m_tos);
        check(tag, "nos", nos, m_nos);
        check(tag, "sp", W'(sp), W'(m_sp));
        check(tag, "lit", W'(lit), W'(m_lit));
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1;
        cmd = 3'd0;
        sp_we = 1'b0;
        repeat (2) @(posedge clk);
        m_tos = '0;
        m_nos = '0;
        m_sp  = 0;
        m_lit = 1'b0;
        @(negedge clk);
        compare_all(tag);
        rst = 1'b0;
    endtask

    task automatic step(input logic [2:0] c, input logic [6:0] n, input logic [W-1:0] v,
                        input logic we, input logic [3:0] wd, input string tag);
        logic [W-1:0] o_tos;
        logic [W-1:0] o_nos;
        int           o_sp;
        cmd = c;
        nib = n;
        tos_in = v;
        sp_we = we;
        sp_wdata = wd;
        @(posedge clk);
        o_tos = m_tos;
        o_nos = m_nos;
        o_sp  = m_sp;
        case (c)
            3'd1: begin
                m_ram[(o_sp + 1) % D] = o_nos;
                m_nos = o_tos;
                m_sp  = (o_sp + 1) % D;
            end
            3'd2: begin
                m_tos = o_nos;
                m_nos = m_ram[o_sp];
                m_sp  = (o_sp + D - 1) % D;
            end
            3'd3: m_tos = v;
            3'd4: begin
                m_tos = v;
                m_nos = m_ram[o_sp];
                m_sp  = (o_sp + D - 1) % D;
            end
            3'd5: begin
                m_ram[(o_sp + 1) % D] = o_nos;
                m_nos = o_tos;
                m_tos = v;
                m_sp  = (o_sp + 1) % D;
            end
            3'd6: begin
                if (m_lit) begin
                    m_tos = (o_tos << 7) | W'(n);
                end else begin
                    m_ram[(o_sp + 1) % D] = o_nos;
                    m_nos = o_tos;
                    m_tos = W'(signed'(n));
                    m_sp  = (o_sp + 1) % D;
                end
            end
            default: ;
        endcase
        m_lit = (c == 3'd6);
        if (we) m_sp = int'(wd);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset("R1");
        // literal runs
        step(3'd6, 7'h7F, '0, 1'b0, '0, "R2");
        step(3'd6, 7'h12, '0, 1'b0, '0, "R3");
        step(3'd6, 7'h55, '0, 1'b0, '0, "R3");
        step(3'd0, '0, '0, 1'b0, '0, "R4");
        step(3'd6, 7'h05, '0, 1'b0, '0, "R2");
        step(3'd6, 7'h40, '0, 1'b0, '0, "R3");
        step(3'd7, '0, '0, 1'b0, '0, "R9");
        step(3'd6, 7'h40, '0, 1'b0, '0, "R2");
        // fill the whole RAM with pushes, wrapping the pointer
        for (int i = 0; i < D + 2; i++) begin
            step(3'd3, '0, W'(16'h1000 + i * 16'h0111), 1'b0, '0, "R7");
            step(3'd1, '0, '0, 1'b0, '0, "R11");
        end
        // drain past zero
        for (int i = 0; i < D + 3; i++) begin
            step(3'd2, '0, '0, 1'b0, '0, "R6");
        end
        step(3'd4, '0, 16'hBEEF, 1'b0, '0, "R8");
        step(3'd5, '0, 16'hCAFE, 1'b0, '0, "R8");
        step(3'd5, '0, 16'h0F0F, 1'b0, '0, "R8");
        step(3'd4, '0, 16'h1234, 1'b0, '0, "R8");
        step(3'd0, '0, '0, 1'b0, '0, "R9");
        step(3'd7, '0, '0, 1'b0, '0, "R9");
        // pointer override
        step(3'd0, '0, '0, 1'b1, 4'd9, "R10");
        step(3'd1, '0, '0, 1'b1, 4'd3, "R10");
        step(3'd2, '0, '0, 1'b1, 4'd15, "R10");
        step(3'd6, 7'h33, '0, 1'b1, 4'd7, "R10");
        step(3'd6, 7'h01, '0, 1'b1, 4'd2, "R10");
        step(3'd2, '0, '0, 1'b0, '0, "R6");
        step(3'd2, '0, '0, 1'b0, '0, "R11");
        step(3'd2, '0, '0, 1'b0, '0, "R11");
        // long literal truncated to width
        step(3'd6, 7'h3A, '0, 1'b0, '0, "R2");
        step(3'd6, 7'h6B, '0, 1'b0, '0, "R3");
        step(3'd6, 7'h1C, '0, 1'b0, '0, "R3");
        step(3'd6, 7'h7E, '0, 1'b0, '0, "R3");
        step(3'd1, '0, '0, 1'b0, '0, "R4");
        // reset mid-run, RAM kept
        do_reset("R1");
        step(3'd2, '0, '0, 1'b0, '0, "R11");
        step(3'd2, '0, '0, 1'b0, '0, "R6");
        step(3'd6, 7'h41, '0, 1'b0, '0, "R2");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule